// File: doc/BRIEF.md
# Storage Controller Host Register Bank

This block is the host-visible register bank of a storage controller. The host reaches it through a simple 32-bit read/write bus. It keeps the interrupt mask, an outbound doorbell, a firmware state word and a diagnostic register. It composes the status and scratch-pad words the host driver polls. Writes to the inbound queue port are split into a frame address and a frame count, which are presented on a one-cycle strobe. A later stage takes them from there.

An adapter reset is guarded. The diagnostic register only accepts a reset command after the host has written an exact six-value unlock sequence to a dedicated sequence register. Any wrong value restarts the sequence. The block signals every reset cause on a single registered one-cycle soft-reset pulse. The reset causes are an unlocked diagnostic reset command and an interrupt-disable write.

Top module: `stor_host_regs`

Bus timing: a write takes effect on the clock edge where `wr_en_i` is high. A read issued with `rd_en_i` returns `rd_data_o` with `rd_valid_o` one cycle later. The returned value reflects the state at the request edge. Register offsets are: firmware init 0x00, outbound status 0x30, interrupt mask 0x34, doorbell 0xA0, scratch 0 0xB0, scratch 1 0xB4, queue low 0xC0, queue high 0xC4, sequence 0xF0, diagnostic 0xF8.

## Requirements
- R1: After reset the interrupt mask reads 0xFFFFFFFF, the doorbell and the diagnostic register read 0, and the firmware state is ready (0xB in bits 31:28).
- R2: Writing 0x00, 0x04, 0x0B, 0x02, 0x07, 0x0D to the sequence register (0xF0), in that order, sets diagnostic bit 7, so the diagnostic register reads 0x80.
- R3: A sequence write that differs from the next expected value restarts matching at the first value. This holds even when the written value is 0x00. Such a write leaves the diagnostic register at 0.
- R4: Once all six values have matched, further sequence writes of any value are ignored, and the diagnostic register keeps reading 0x80.
- R5: A diagnostic write (0xF8) with bit 2 set while bit 7 is set produces exactly one soft-reset pulse. It returns the diagnostic register to 0 and restarts matching, so a new unlock needs all six values.
- R6: A diagnostic write while bit 7 is clear produces no soft-reset pulse and leaves the register at 0.
- R7: A read of scratch 1 (0xB4) returns 15. Reads of undecoded offsets return 0, and writes to them change no readable register.
- R8: Scratch 0 (0xB0) reads as the firmware state in bits 31:28, OR bit 26 when MSI-X is enabled, OR the low 8 bits of the scatter-gather limit in bits 23:16, OR the command limit in bits 15:0. With the default parameters this is 0xB45003F0.
- R9: Writing 0xFFFFFFFF to the interrupt mask produces one soft-reset pulse. Any other mask value produces none. The mask reads back as written.
- R10: A firmware-init write (0x00) with bit 5 set puts the firmware state into fault (0xF in bits 31:28). A write without bit 5 leaves the state unchanged.
- R11: A write to the queue low port (0xC0) raises `frame_vld_o` for one cycle on the next cycle. The frame address is {queue high word, data[31:5], 5'b0} and the frame count is data[4:1].
- R12: The outbound status (0x30) reads the ready constant (default 0x20000001) when the mask is not 0xFFFFFFFF and the doorbell is nonzero. Otherwise it reads 0.
- R13: Bits set on `db_set_i` are ORed into the doorbell. A write to the doorbell clears the bits that are 1 in the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset |
| wr_data_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| rd_data_o | output | 32 | Read data |
| db_set_i | input | 32 | Doorbell bits to set |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |
| frame_vld_o | output | 1 | Frame decode strobe |
| frame_addr_o | output | 64 | Decoded frame address |
| frame_cnt_o | output | 4 | Decoded frame count |

## Verification
A wrong match count in the unlock logic has two visible effects. The diagnostic register reads 0x80 one write too early or too late, and a gated reset command gives a soft-reset pulse where none belongs, one cycle after the write. To catch a counter that failed to restart, the bench clears the unlock and then writes five correct values. The diagnostic read must still return 0. Mistakes in the firmware state, the mask or the doorbell appear in the composed scratch and status reads on the cycle after the request. The frame outputs are compared on the strobe cycle that follows each queue write.

// File: rtl/stor_regs_pkg.sv
package stor_regs_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int SEQ_LEN = 6;

  localparam logic [ADDR_W-1:0] OFF_FWINIT = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_OSTS   = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_IMASK  = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_DBELL  = 8'hA0;
  localparam logic [ADDR_W-1:0] OFF_SCR0   = 8'hB0;
  localparam logic [ADDR_W-1:0] OFF_SCR1   = 8'hB4;
  localparam logic [ADDR_W-1:0] OFF_QLO    = 8'hC0;
  localparam logic [ADDR_W-1:0] OFF_QHI    = 8'hC4;
  localparam logic [ADDR_W-1:0] OFF_SEQ    = 8'hF0;
  localparam logic [ADDR_W-1:0] OFF_DIAG   = 8'hF8;

  localparam int DIAG_WE_BIT  = 7;
  localparam int DIAG_RST_BIT = 2;
  localparam int FWI_STOP_BIT = 5;

  localparam logic [DATA_W-1:0] FW_STATE_MASK = 32'hF000_0000;
  localparam logic [DATA_W-1:0] FW_READY      = 32'hB000_0000;
  localparam logic [DATA_W-1:0] FW_FAULT      = 32'hF000_0000;
  localparam logic [DATA_W-1:0] MSIX_FLAG     = 32'h0400_0000;
  localparam logic [DATA_W-1:0] SCR1_CONST    = 32'd15;
  localparam logic [DATA_W-1:0] IMASK_OFF     = 32'hFFFF_FFFF;

  // unlock sequence, order is behaviour
  function automatic logic [DATA_W-1:0] seq_value(input int unsigned idx);
    case (idx)
      0:       return 32'h00;
      1:       return 32'h04;
      2:       return 32'h0B;
      3:       return 32'h02;
      4:       return 32'h07;
      5:       return 32'h0D;
      default: return 32'h00;
    endcase
  endfunction
endpackage

// File: rtl/stor_unlock.sv
module stor_unlock
  import stor_regs_pkg::*;
#(
  parameter int LEN   = SEQ_LEN,
  localparam int CNT_W = $clog2(LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seq_wr_i,
  input  logic              diag_wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] diag_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              adp_rst_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             unlocked;

  assign unlocked  = (cnt_q == CNT_W'(LEN));
  assign adp_rst_o = diag_wr_i && unlocked && wr_data_i[DIAG_RST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (adp_rst_o) begin
      cnt_q <= '0;
    end else if (seq_wr_i && !unlocked) begin
      if (wr_data_i == seq_value(int'(cnt_q))) cnt_q <= cnt_q + 1'b1;
      else                                     cnt_q <= '0;
    end
  end

  always_comb begin
    diag_o = '0;
    diag_o[DIAG_WE_BIT] = unlocked;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/stor_qport.sv
module stor_qport
  import stor_regs_pkg::*;
#(
  parameter int FA_W = 64,
  parameter int FC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_wr_i,
  input  logic              lo_wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              frame_vld_o,
  output logic [FA_W-1:0]   frame_addr_o,
  output logic [FC_W-1:0]   frame_cnt_o
);
  logic [DATA_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q         <= '0;
      frame_vld_o  <= 1'b0;
      frame_addr_o <= '0;
      frame_cnt_o  <= '0;
    end else begin
      frame_vld_o <= lo_wr_i;
      if (hi_wr_i) hi_q <= wr_data_i;
      if (lo_wr_i) begin
        frame_addr_o <= {hi_q, wr_data_i[DATA_W-1:5], 5'b0};
        frame_cnt_o  <= wr_data_i[FC_W:1];
      end
    end
  end

  logic unused_bits;
  assign unused_bits = wr_data_i[0];
endmodule

// File: rtl/stor_host_regs.sv
module stor_host_regs
  import stor_regs_pkg::*;
#(
  parameter int                SGE_LIMIT  = 80,
  parameter int                MAX_CMDS   = 1008,
  parameter bit                MSIX_EN    = 1'b1,
  parameter logic [DATA_W-1:0] OSTS_READY = 32'h2000_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [DATA_W-1:0] db_set_i,
  output logic              soft_rst_o,
  output logic              frame_vld_o,
  output logic [63:0]       frame_addr_o,
  output logic [3:0]        frame_cnt_o
);
  localparam int CNT_W = $clog2(SEQ_LEN + 1);
  localparam logic [DATA_W-1:0] SCR0_FIXED =
      (MSIX_EN ? MSIX_FLAG : '0) |
      (DATA_W'(SGE_LIMIT & 8'hFF) << 16) |
      DATA_W'(MAX_CMDS & 16'hFFFF);

  logic [DATA_W-1:0] imask_q, dbell_q, fw_state_q, diag_val, rd_mux;
  logic [CNT_W-1:0]  seq_cnt;
  logic              adp_rst, imask_off_wr;
  logic              wr_fwinit, wr_imask, wr_dbell, wr_seq, wr_diag, wr_qlo, wr_qhi;

  assign wr_fwinit = wr_en_i && (addr_i == OFF_FWINIT);
  assign wr_imask  = wr_en_i && (addr_i == OFF_IMASK);
  assign wr_dbell  = wr_en_i && (addr_i == OFF_DBELL);
  assign wr_seq    = wr_en_i && (addr_i == OFF_SEQ);
  assign wr_diag   = wr_en_i && (addr_i == OFF_DIAG);
  assign wr_qlo    = wr_en_i && (addr_i == OFF_QLO);
  assign wr_qhi    = wr_en_i && (addr_i == OFF_QHI);

  assign imask_off_wr = wr_imask && (wr_data_i == IMASK_OFF);

  stor_unlock #(.LEN(SEQ_LEN)) u_unlock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .seq_wr_i (wr_seq),
    .diag_wr_i(wr_diag),
    .wr_data_i(wr_data_i),
    .diag_o   (diag_val),
    .cnt_o    (seq_cnt),
    .adp_rst_o(adp_rst)
  );

  stor_qport #(.FA_W(64), .FC_W(4)) u_qport (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hi_wr_i     (wr_qhi),
    .lo_wr_i     (wr_qlo),
    .wr_data_i   (wr_data_i),
    .frame_vld_o (frame_vld_o),
    .frame_addr_o(frame_addr_o),
    .frame_cnt_o (frame_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imask_q    <= IMASK_OFF;
      dbell_q    <= '0;
      fw_state_q <= FW_READY;
      soft_rst_o <= 1'b0;
    end else begin
      soft_rst_o <= imask_off_wr || adp_rst;
      if (wr_imask) imask_q <= wr_data_i;
      dbell_q <= (dbell_q & ~(wr_dbell ? wr_data_i : '0)) | db_set_i;
      if (wr_fwinit && wr_data_i[FWI_STOP_BIT]) fw_state_q <= FW_FAULT;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      OFF_OSTS:  rd_mux = ((imask_q != IMASK_OFF) && (dbell_q != '0)) ? OSTS_READY : '0;
      OFF_IMASK: rd_mux = imask_q;
      OFF_DBELL: rd_mux = dbell_q;
      OFF_SCR0:  rd_mux = (fw_state_q & FW_STATE_MASK) | SCR0_FIXED;
      OFF_SCR1:  rd_mux = SCR1_CONST;
      OFF_DIAG:  rd_mux = diag_val;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end
endmodule

// File: rtl/stor_host_regs_chk.sv
module stor_host_regs_chk
  import stor_regs_pkg::*;
#(
  parameter int CNT_W = $clog2(SEQ_LEN + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              soft_rst_o,
  input logic              frame_vld_o,
  input logic [3:0]        frame_cnt_o,
  input logic [CNT_W-1:0]  seq_cnt_i
);
  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_cnt_i <= CNT_W'(SEQ_LEN));

  assert_hold_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_SEQ && seq_cnt_i == CNT_W'(SEQ_LEN))
    |=> seq_cnt_i == CNT_W'(SEQ_LEN));

  assert_mismatch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_SEQ && seq_cnt_i != CNT_W'(SEQ_LEN) &&
     wr_data_i != seq_value(int'(seq_cnt_i))) |=> seq_cnt_i == '0);

  assert_adp_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_DIAG && wr_data_i[DIAG_RST_BIT] &&
     seq_cnt_i == CNT_W'(SEQ_LEN)) |=> (soft_rst_o && seq_cnt_i == '0));

  assert_locked_diag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_DIAG && seq_cnt_i != CNT_W'(SEQ_LEN)) |=> !soft_rst_o);

  assert_scr1_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFF_SCR1) |=> (rd_valid_o && rd_data_o == SCR1_CONST));

  assert_frame_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_QLO) |=> (frame_vld_o && frame_cnt_o == $past(wr_data_i[4:1])));
endmodule

bind stor_host_regs stor_host_regs_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wr_data_i  (wr_data_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .soft_rst_o (soft_rst_o),
  .frame_vld_o(frame_vld_o),
  .frame_cnt_o(frame_cnt_o),
  .seq_cnt_i  (seq_cnt)
);

// File: tb/stor_host_regs_test.sv
module stor_host_regs_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wr_data_i = '0, db_set_i = '0;
  logic        rd_valid_o, soft_rst_o, frame_vld_o;
  logic [31:0] rd_data_o;
  logic [63:0] frame_addr_o;
  logic [3:0]  frame_cnt_o;

  int checks = 0, fails = 0, pulses = 0;
  logic [31:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [67:0] fr_exp_q[$];

  always #2 clk_i = ~clk_i;

  stor_host_regs uut (.*);

  task automatic result(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitors
  always @(negedge clk_i) begin
    if (rd_valid_o) begin
      if (rd_exp_q.size() == 0) result(1'b0, "unexpected read", 68'(rd_data_o), 68'(0));
      else begin
        automatic logic [31:0] e = rd_exp_q.pop_front();
        automatic string t = rd_tag_q.pop_front();
        result(rd_data_o == e, t, 68'(rd_data_o), 68'(e));
      end
    end
    if (frame_vld_o) begin
      if (fr_exp_q.size() == 0) result(1'b0, "R11 unexpected frame", {frame_cnt_o, frame_addr_o}, 68'(0));
      else begin
        automatic logic [67:0] e = fr_exp_q.pop_front();
        result({frame_cnt_o, frame_addr_o} == e, "R11 frame", {frame_cnt_o, frame_addr_o}, e);
      end
    end
    if (soft_rst_o) pulses++;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    rd_exp_q.push_back(exp);
    rd_tag_q.push_back(tag);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic chk_pulses(input int exp, input string tag);
    @(negedge clk_i); #1;
    result(pulses == exp, tag, 68'(pulses), 68'(exp));
  endtask

  task automatic unlock(input int n);
    for (int i = 0; i < n; i++) wr(8'hF0, stor_regs_pkg::seq_value(i));
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state, R8 composed scratch
    rd(8'h34, 32'hFFFF_FFFF, "R1 mask reset");
    rd(8'hA0, 32'h0, "R1 doorbell reset");
    rd(8'hF8, 32'h0, "R1 diag reset");
    rd(8'hB0, 32'hB450_03F0, "R8 scratch0 ready");
    // R7 constants and undecoded space
    rd(8'hB4, 32'd15, "R7 scratch1");
    wr(8'h44, 32'hDEAD_BEEF);
    rd(8'h44, 32'h0, "R7 undecoded read");
    rd(8'h34, 32'hFFFF_FFFF, "R7 undecoded write no effect");
    // R2 unlock, R4 hold
    unlock(6);
    rd(8'hF8, 32'h80, "R2 unlocked");
    wr(8'hF0, 32'h55);
    wr(8'hF0, 32'h00);
    rd(8'hF8, 32'h80, "R4 holds after extra writes");
    // R5 gated reset
    wr(8'hF8, 32'h04);
    chk_pulses(1, "R5 one pulse");
    rd(8'hF8, 32'h0, "R5 diag cleared");
    unlock(5);
    rd(8'hF8, 32'h0, "R5 counter restarted");
    wr(8'hF0, 32'h0D);
    rd(8'hF8, 32'h80, "R5 relock needs six");
    wr(8'hF8, 32'h80);
    chk_pulses(1, "R5 no pulse without bit2");
    wr(8'hF8, 32'h04);
    chk_pulses(2, "R5 second pulse");
    // R3 mismatch restart, including value 0x00
    wr(8'hF0, 32'h00); wr(8'hF0, 32'h04); wr(8'hF0, 32'h00);
    for (int i = 1; i < 6; i++) wr(8'hF0, stor_regs_pkg::seq_value(i));
    rd(8'hF8, 32'h0, "R3 restart on mismatching 0x00");
    unlock(4); wr(8'hF0, 32'h99); unlock(5);
    rd(8'hF8, 32'h0, "R3 restart mid sequence");
    wr(8'hF0, 32'h0D);
    rd(8'hF8, 32'h80, "R3 full after restart");
    wr(8'hF8, 32'h04);
    chk_pulses(3, "R5 third pulse");
    // R6 locked diag write
    wr(8'hF8, 32'h84);
    chk_pulses(3, "R6 no pulse locked");
    rd(8'hF8, 32'h0, "R6 diag stays zero");
    // R9 mask
    wr(8'h34, 32'h0);
    chk_pulses(3, "R9 no pulse on enable");
    rd(8'h34, 32'h0, "R9 mask readback");
    // R13 doorbell, R12 status
    rd(8'h30, 32'h0, "R12 status zero empty doorbell");
    @(negedge clk_i); db_set_i = 32'h5;
    @(negedge clk_i); db_set_i = 32'h0;
    rd(8'hA0, 32'h5, "R13 doorbell set");
    rd(8'h30, 32'h2000_0001, "R12 status ready");
    wr(8'hA0, 32'h1);
    rd(8'hA0, 32'h4, "R13 doorbell clear");
    wr(8'h34, 32'hFFFF_FFFF);
    chk_pulses(4, "R9 pulse on disable");
    rd(8'h30, 32'h0, "R12 status masked");
    wr(8'h34, 32'h0000_0001);
    chk_pulses(4, "R9 no pulse partial mask");
    rd(8'h30, 32'h2000_0001, "R12 status partial mask");
    // R10 firmware state
    wr(8'h00, 32'h1);
    rd(8'hB0, 32'hB450_03F0, "R10 no stop bit");
    wr(8'h00, 32'h20);
    rd(8'hB0, 32'hF450_03F0, "R10 fault");
    // R11 queue port
    wr(8'hC4, 32'h1234_5678);
    fr_exp_q.push_back({4'hD, 64'h1234_5678_ABCD_EF40});
    wr(8'hC0, 32'hABCD_EF5A);
    fr_exp_q.push_back({4'hF, 64'h1234_5678_0000_0000});
    wr(8'hC0, 32'h0000_001F);
    repeat (3) @(negedge clk_i);
    result(fr_exp_q.size() == 0, "R11 all frames seen", 68'(fr_exp_q.size()), 68'(0));
    result(rd_exp_q.size() == 0, "R7 all reads returned", 68'(rd_exp_q.size()), 68'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule